// File: doc/BRIEF.md
# Toggle-Handshake Single-Port RAM

This block is a single-port synchronous word memory that a controller drives through a token handshake instead of a level enable. The controller keeps a request token and the memory keeps an acknowledge token. The controller sets up an address, a write flag and write data. It then makes its request token differ from the acknowledge token. A request counts as outstanding for as long as the two tokens hold different values.

On the next rising clock edge the memory serves the request. It either stores the write data at the addressed word or loads that word into a registered read output. In the same edge it copies the request token into its acknowledge token, which closes the request. To issue a new request, the controller increments or toggles its token again. Because the acknowledge updates in the same edge that serves a request, requests can follow each other on consecutive cycles.

Top module: `token_sp_ram`

## Requirements
- R1: A synchronous active-high reset clears the acknowledge token and the read output to zero. While reset is held, no request is served.
- R2: While the request token equals the acknowledge token, nothing changes: the memory, the read output and the acknowledge token all keep their values, whatever the address, write flag and write data are.
- R3: The two tokens are compared over their full width (32 bits by default). Tokens that differ only in the top bit still form an outstanding request.
- R4: When the tokens differ and the write flag is 1, the write data is stored at the addressed word at the next rising edge.
- R5: When the tokens differ and the write flag is 0, the addressed word appears on the read output after the next rising edge.
- R6: A served write leaves the read output unchanged.
- R7: A served read leaves the memory contents unchanged, whatever value is on the write data input.
- R8: At the edge that serves a request, the acknowledge token takes the value of the request token. A new request may therefore be issued in the very next cycle, so one request can be served on every edge.
- R9: A word that has never been written reads as zero.
- R10: The address is an unsigned word index with no offset. Word 0 and word DEPTH-1 are separate storage locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_tok_i | input | TOK_W | Controller request token |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | $clog2(DEPTH) | Word index |
| wdata_i | input | DATA_W | Data to store |
| ack_tok_o | output | TOK_W | Acknowledge token, registered |
| rdata_o | output | DATA_W | Registered read data |

## Verification
Every result of a request comes one rising edge after that request is set up: the acknowledge copy, the stored word and the read output. The bench changes inputs on falling edges. It samples the outputs on the falling edge that follows the serving edge. It then sets up the next request at that same falling edge, so back-to-back traffic is tested without gaps. A write is checked by reading the same address on the following edge. Idle cycles are checked in two ways. First, the outputs are sampled across several falling edges while the tokens match. Second, the addresses that idle stimulus could have changed are read back afterwards.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic [1:0] {
    TSR_IDLE  = 2'd0,
    TSR_WRITE = 2'd1,
    TSR_READ  = 2'd2
  } tsr_op_e;
endpackage

// File: rtl/tsr_req_decode.sv
module tsr_req_decode
  import tsr_pkg::*;
#(
  parameter int TOK_W = 32
) (
  input  logic             rst,
  input  logic [TOK_W-1:0] req_tok,
  input  logic [TOK_W-1:0] ack_tok,
  input  logic             wr_flag,
  output tsr_op_e          op
);
  // Outstanding request whenever the token pair disagrees (full width).
  always_comb begin
    if (rst || (req_tok == ack_tok)) op = TSR_IDLE;
    else if (wr_flag)                op = TSR_WRITE;
    else                             op = TSR_READ;
  end
endmodule

// File: rtl/tsr_ack_reg.sv
module tsr_ack_reg
  import tsr_pkg::*;
#(
  parameter int TOK_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  tsr_op_e          op,
  input  logic [TOK_W-1:0] req_tok,
  output logic [TOK_W-1:0] ack_q
);
  always_ff @(posedge clk) begin
    if (rst)                ack_q <= '0;
    else if (op != TSR_IDLE) ack_q <= req_tok;
  end
endmodule

// File: rtl/tsr_word_store.sv
module tsr_word_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Power-up contents are zero; reset does not touch the array.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Output register with enable and synchronous reset.
  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= mem[addr];
  end
endmodule

// File: rtl/token_sp_ram.sv
module token_sp_ram
  import tsr_pkg::*;
#(
  parameter int  DATA_W = 32,
  parameter int  DEPTH  = 64,
  parameter int  TOK_W  = 32,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TOK_W-1:0]  req_tok_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [TOK_W-1:0]  ack_tok_o,
  output logic [DATA_W-1:0] rdata_o
);
  tsr_op_e op;

  tsr_req_decode #(.TOK_W(TOK_W)) u_decode (
    .rst     (rst),
    .req_tok (req_tok_i),
    .ack_tok (ack_tok_o),
    .wr_flag (wr_i),
    .op      (op)
  );

  tsr_ack_reg #(.TOK_W(TOK_W)) u_ack (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .req_tok (req_tok_i),
    .ack_q   (ack_tok_o)
  );

  tsr_word_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (op == TSR_WRITE),
    .re      (op == TSR_READ),
    .addr    (addr_i),
    .wdata   (wdata_i),
    .rdata_q (rdata_o)
  );
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int TOK_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [TOK_W-1:0]  req_tok,
  input logic [TOK_W-1:0]  ack_tok,
  input logic              wr,
  input logic [DATA_W-1:0] rdata
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ack_tok == '0 && rdata == '0)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (req_tok == ack_tok) |=> ($stable(ack_tok) && $stable(rdata))); // R2

  AST_ACK_COPIES_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_tok != ack_tok) |=> (ack_tok == $past(req_tok))); // R8

  AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (rst)
    (req_tok != ack_tok && wr) |=> $stable(rdata)); // R6

  AST_SERVED_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (req_tok != ack_tok) |=> (ack_tok != $past(ack_tok))); // R3
endmodule

bind token_sp_ram tsr_checker #(.TOK_W(TOK_W), .DATA_W(DATA_W)) u_tsr_chk (
  .clk     (clk),
  .rst     (rst),
  .req_tok (req_tok_i),
  .ack_tok (ack_tok_o),
  .wr      (wr_i),
  .rdata   (rdata_o)
);

// File: tb/test_token_sp_ram.sv
module test_token_sp_ram;
  localparam int DW = 32;
  localparam int DEPTH = 64;
  localparam int TW = 32;
  localparam int AW = 6;
  localparam int NVEC = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] req_tok = '0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [TW-1:0] ack_tok;
  logic [DW-1:0] rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #5 clk = ~clk;

  token_sp_ram #(.DATA_W(DW), .DEPTH(DEPTH), .TOK_W(TW)) i_token_sp_ram (
    .clk(clk), .rst(rst), .req_tok_i(req_tok), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ack_tok_o(ack_tok), .rdata_o(rdata)
  );

  // {wr[70], addr[69:64], wdata[63:32], expected read[31:0]}
  localparam logic [70:0] VEC [NVEC] = '{
    {1'b1, 6'd3,  32'hA5A5_0001, 32'h0},
    {1'b0, 6'd3,  32'h0,         32'hA5A5_0001},
    {1'b1, 6'd63, 32'hDEAD_BEEF, 32'h0},
    {1'b1, 6'd0,  32'h1234_5678, 32'h0},
    {1'b0, 6'd63, 32'h0,         32'hDEAD_BEEF},
    {1'b0, 6'd0,  32'h0,         32'h1234_5678},
    {1'b0, 6'd10, 32'h0,         32'h0},
    {1'b1, 6'd3,  32'h0000_FFFF, 32'h0},
    {1'b0, 6'd3,  32'h0,         32'h0000_FFFF}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Set up a request at a falling edge; results are sampled on the next falling edge.
  task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [TW-1:0] tok);
    wr = w; addr = a; wdata = d; req_tok = tok;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] prev;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(ack_tok == '0, "R1 ack after reset", ack_tok, 32'h0);
    check(rdata == '0, "R1 rdata after reset", rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // Table walk: one request per edge, back to back (R4 R5 R6 R8 R9 R10).
    for (int v = 0; v < NVEC; v++) begin
      prev = rdata;
      issue(VEC[v][70], VEC[v][69:64], VEC[v][63:32], ack_tok + 32'd1);
      check(ack_tok == req_tok, "R8 ack copies request", ack_tok, req_tok);
      if (VEC[v][70]) begin
        ref_mem[VEC[v][69:64]] = VEC[v][63:32];
        check(rdata == prev, "R6 write keeps rdata", rdata, prev);
      end else begin
        check(rdata == VEC[v][31:0], "R5 R9 R10 read value", rdata, VEC[v][31:0]);
        check(rdata == ref_mem[VEC[v][69:64]], "R4 reference compare", rdata, ref_mem[VEC[v][69:64]]);
      end
    end

    // R2: tokens equal, write stimulus present for several cycles.
    prev = rdata;
    wr = 1'b1; addr = 6'd3; wdata = 32'h5555_5555; req_tok = ack_tok;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(ack_tok == req_tok, "R2 ack idle", ack_tok, req_tok);
      check(rdata == prev, "R2 rdata idle", rdata, prev);
    end
    issue(1'b0, 6'd3, 32'h0, ack_tok + 32'd1);
    check(rdata == 32'h0000_FFFF, "R2 idle did not write", rdata, 32'h0000_FFFF);

    // R7: read with garbage write data, then reread.
    issue(1'b0, 6'd0, 32'hFFFF_FFFF, ack_tok + 32'd1);
    issue(1'b0, 6'd0, 32'h0, ack_tok + 32'd1);
    check(rdata == 32'h1234_5678, "R7 read kept memory", rdata, 32'h1234_5678);

    // R3: tokens differ only in the top bit.
    issue(1'b0, 6'd63, 32'h0, ack_tok ^ 32'h8000_0000);
    check(ack_tok == req_tok, "R3 top-bit ack", ack_tok, req_tok);
    check(rdata == 32'hDEAD_BEEF, "R3 top-bit read", rdata, 32'hDEAD_BEEF);

    // R1: reset mid-run with a pending request that must not be served.
    rst = 1'b1;
    issue(1'b1, 6'd10, 32'hCAFE_0000, ack_tok + 32'd7);
    check(ack_tok == '0, "R1 ack cleared", ack_tok, 32'h0);
    check(rdata == '0, "R1 rdata cleared", rdata, 32'h0);
    req_tok = '0;
    @(negedge clk);
    rst = 1'b0;
    issue(1'b0, 6'd10, 32'h0, 32'd1);
    check(rdata == 32'h0, "R1 no write during reset", rdata, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule